// File: doc/BRIEF.md
# DMA Channel Programming Register Interface

This block is the software-visible register file of a four-channel DMA controller reached over a byte-wide I/O bus. Every channel owns a 16-bit address register and a 16-bit count register. Each register has a base copy, which holds the value software programmed, and a current copy, which advances as transfers proceed. One flip-flop is shared by all channels and steers each 8-bit access to the low or high half of a 16-bit register. Software resets that flip-flop through a dedicated clear port before it moves a 16-bit value.

Per-channel mask, direction and autoinitialize bits are set through a single-channel mask port and a mode port. A transfer-step strobe stands in for the transfer engine. Each strobe on an unmasked channel advances its address and decrements its count. When the count steps past zero, terminal count is reached. The count then wraps to 0xFFFF and the channel masks itself, unless autoinitialize is set; in that case the current copies are reloaded from the base copies and the channel stays enabled.

A parameter selects a word-wide bus variant. In that variant every port offset is doubled and accesses at odd offsets are not decoded.

Top module: `dma_regfile`

## Requirements
- R1: After reset all four channels are masked (mask_o = 4'hF), auto_o, dir_o and tc_o are zero, every address and count register reads 0x0000, and the byte pointer selects the low byte.
- R2: With the byte bus (WORD_BUS = 0), channel c's address register is at offset 2*c and its count register at offset 2*c+1. The mask port is at offset 10, the mode port at 11 and the byte-pointer clear port at 12. With WORD_BUS = 1 every offset is doubled.
- R3: A write of any value to the clear port makes the next address or count access use the low byte.
- R4: Every read or write of an address or count register toggles the shared byte pointer. The first access after a clear uses bits 7:0 and the second uses bits 15:8; a third access uses the low byte again.
- R5: Writing an address or count byte loads that byte into both the base and the current copy.
- R6: A mask-port write uses data bits 1:0 as the channel number and bit 2 as the new mask value (1 masks, 0 enables). The result is visible on mask_o one cycle later.
- R7: A mode-port write uses bits 1:0 as the channel number, bit 4 as autoinitialize (1 = auto) and bit 2 as direction (1 = device to memory). The result is shown on auto_o and dir_o one cycle later.
- R8: A step strobe on an unmasked channel adds one to its current address and subtracts one from its current count.
- R9: A step while the current count is 0 in single mode leaves the count at 0xFFFF and sets the channel's mask bit. It also pulses that channel's tc_o bit for one cycle.
- R10: A step while the current count is 0 in autoinitialize mode pulses tc_o, reloads the current address and count from the base copies and leaves the channel enabled.
- R11: A step strobe on a masked channel changes neither its address, its count nor tc_o.
- R12: Read data appears on rdata the cycle after rd_en. Reads of offsets other than address or count registers return 0x00 and leave the byte pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, takes precedence over rd_en |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 4+WORD_BUS | Port offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| step_en | input | 1 | Transfer-step strobe |
| step_ch | input | 2 | Channel stepped by step_en |
| mask_o | output | 4 | Per-channel mask bits |
| auto_o | output | 4 | Per-channel autoinitialize bits |
| dir_o | output | 4 | Per-channel direction bits (1 = device to memory) |
| tc_o | output | 4 | One-cycle terminal-count pulse per channel |

## Verification
Every result is due exactly one clock edge after its stimulus: register contents, mask_o, auto_o and dir_o after a write, rdata after rd_en, and count, address and tc_o after a step strobe. The bench drives each strobe on the falling edge for one cycle. It samples on the following falling edge, after the single registering edge, so that the one-cycle tc_o pulse is caught in the cycle it exists. Register contents are checked through byte-serial reads that first clear the pointer, so the check path is the same bus path under test.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int NCH    = 4;
    localparam int CH_W   = 2;
    localparam int DATA_W = 8;
    localparam int REG_W  = 16;

    localparam logic [3:0] OFS_MASK  = 4'd10;
    localparam logic [3:0] OFS_MODE  = 4'd11;
    localparam logic [3:0] OFS_CLEAR = 4'd12;
    localparam int         MODE_AUTO_BIT = 4;
    localparam int         MODE_DIR_BIT  = 2;
    localparam int         MASK_VAL_BIT  = 2;

    typedef struct packed {
        logic [REG_W-1:0] base_addr;
        logic [REG_W-1:0] cur_addr;
        logic [REG_W-1:0] base_cnt;
        logic [REG_W-1:0] cur_cnt;
        logic             mask;
        logic             auto_en;
        logic             dir;
        logic             tc;
    } chan_t;
endpackage

// File: rtl/dma_decode.sv
module dma_decode #(
    parameter int WORD_BUS = 0,
    localparam int ADDR_W  = 4 + WORD_BUS
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              reg_hit,
    output logic              reg_acc,
    output logic [1:0]        ch,
    output logic              is_cnt,
    output logic              mask_wr,
    output logic              mode_wr,
    output logic              clr_wr
);
    import dma_pkg::*;

    logic [3:0] ofs;
    logic       aligned;

    generate
        if (WORD_BUS != 0) begin : g_word
            assign ofs     = addr[ADDR_W-1:1];
            assign aligned = ~addr[0];
        end else begin : g_byte
            assign ofs     = addr[3:0];
            assign aligned = 1'b1;
        end
    endgenerate

    always_comb begin
        reg_hit = aligned && (ofs[3] == 1'b0);
        ch      = ofs[2:1];
        is_cnt  = ofs[0];
        reg_acc = reg_hit && (wr_en || rd_en);
        mask_wr = wr_en && aligned && (ofs == OFS_MASK);
        mode_wr = wr_en && aligned && (ofs == OFS_MODE);
        clr_wr  = wr_en && aligned && (ofs == OFS_CLEAR);
    end
endmodule

// File: rtl/dma_byteptr.sv
module dma_byteptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic acc_i,
    output logic hi_o
);
    logic ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr_i)      ptr_d = 1'b0;
        else if (acc_i) ptr_d = ~ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= 1'b0;
        else        ptr_q <= ptr_d;
    end

    assign hi_o = ptr_q;

    a_r3_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !hi_o);
    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !clr_i) |=> (hi_o != $past(hi_o)));
endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr_i,
    input  logic              ld_cnt_i,
    input  logic              hi_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              mask_wr_i,
    input  logic              mask_val_i,
    input  logic              mode_wr_i,
    input  logic              mode_auto_i,
    input  logic              mode_dir_i,
    input  logic              step_i,
    output logic [REG_W-1:0]  cur_addr_o,
    output logic [REG_W-1:0]  cur_cnt_o,
    output logic              mask_o,
    output logic              auto_o,
    output logic              dir_o,
    output logic              tc_o
);
    chan_t ch_d, ch_q;

    always_comb begin
        ch_d    = ch_q;
        ch_d.tc = 1'b0;

        if (step_i && !ch_q.mask) begin
            ch_d.cur_addr = ch_q.cur_addr + 1'b1;
            ch_d.cur_cnt  = ch_q.cur_cnt - 1'b1;
            if (ch_q.cur_cnt == '0) begin
                ch_d.tc = 1'b1;
                if (ch_q.auto_en) begin
                    ch_d.cur_addr = ch_q.base_addr;
                    ch_d.cur_cnt  = ch_q.base_cnt;
                end else begin
                    ch_d.mask = 1'b1;
                end
            end
        end

        if (ld_addr_i) begin
            if (hi_i) begin
                ch_d.base_addr[15:8] = wdata_i;
                ch_d.cur_addr[15:8]  = wdata_i;
            end else begin
                ch_d.base_addr[7:0] = wdata_i;
                ch_d.cur_addr[7:0]  = wdata_i;
            end
        end

        if (ld_cnt_i) begin
            if (hi_i) begin
                ch_d.base_cnt[15:8] = wdata_i;
                ch_d.cur_cnt[15:8]  = wdata_i;
            end else begin
                ch_d.base_cnt[7:0] = wdata_i;
                ch_d.cur_cnt[7:0]  = wdata_i;
            end
        end

        if (mask_wr_i) ch_d.mask = mask_val_i;
        if (mode_wr_i) begin
            ch_d.auto_en = mode_auto_i;
            ch_d.dir     = mode_dir_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q      <= '0;
            ch_q.mask <= 1'b1;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign cur_addr_o = ch_q.cur_addr;
    assign cur_cnt_o  = ch_q.cur_cnt;
    assign mask_o     = ch_q.mask;
    assign auto_o     = ch_q.auto_en;
    assign dir_o      = ch_q.dir;
    assign tc_o       = ch_q.tc;

    a_r9_single_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !mask_o && !auto_o && cur_cnt_o == '0 && !mask_wr_i)
        |=> (mask_o && tc_o));
    a_r10_auto_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !mask_o && auto_o && cur_cnt_o == '0 && !ld_cnt_i)
        |=> (cur_cnt_o == $past(ch_q.base_cnt) && tc_o));
    a_r11_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mask_o && !ld_cnt_i) |=> ($stable(cur_cnt_o) && !tc_o));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_pkg::*;
#(
    parameter int WORD_BUS = 0,
    localparam int ADDR_W  = 4 + WORD_BUS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              step_en,
    input  logic [CH_W-1:0]   step_ch,
    output logic [NCH-1:0]    mask_o,
    output logic [NCH-1:0]    auto_o,
    output logic [NCH-1:0]    dir_o,
    output logic [NCH-1:0]    tc_o
);
    logic            reg_hit, reg_acc, is_cnt, mask_wr, mode_wr, clr_wr, hi;
    logic [CH_W-1:0] dec_ch;
    logic [REG_W-1:0] cur_addr [NCH];
    logic [REG_W-1:0] cur_cnt  [NCH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    dma_decode #(.WORD_BUS(WORD_BUS)) u_dec (
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .reg_hit(reg_hit), .reg_acc(reg_acc), .ch(dec_ch), .is_cnt(is_cnt),
        .mask_wr(mask_wr), .mode_wr(mode_wr), .clr_wr(clr_wr)
    );

    dma_byteptr u_ptr (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_wr), .acc_i(reg_acc), .hi_o(hi)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            dma_channel u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .ld_addr_i  (wr_en && reg_hit && !is_cnt && dec_ch == CH_W'(c)),
                .ld_cnt_i   (wr_en && reg_hit &&  is_cnt && dec_ch == CH_W'(c)),
                .hi_i       (hi),
                .wdata_i    (wdata),
                .mask_wr_i  (mask_wr && wdata[1:0] == CH_W'(c)),
                .mask_val_i (wdata[MASK_VAL_BIT]),
                .mode_wr_i  (mode_wr && wdata[1:0] == CH_W'(c)),
                .mode_auto_i(wdata[MODE_AUTO_BIT]),
                .mode_dir_i (wdata[MODE_DIR_BIT]),
                .step_i     (step_en && step_ch == CH_W'(c)),
                .cur_addr_o (cur_addr[c]),
                .cur_cnt_o  (cur_cnt[c]),
                .mask_o     (mask_o[c]),
                .auto_o     (auto_o[c]),
                .dir_o      (dir_o[c]),
                .tc_o       (tc_o[c])
            );
        end
    endgenerate

    always_comb begin
        logic [REG_W-1:0] word;
        rdata_d = rdata_q;
        word    = is_cnt ? cur_cnt[dec_ch] : cur_addr[dec_ch];
        if (rd_en && !wr_en) begin
            if (reg_hit) rdata_d = hi ? word[15:8] : word[7:0];
            else         rdata_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    a_r9_tc_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_o));
    a_r6_mask_port: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_o[$past(wdata[1:0])] == $past(wdata[MASK_VAL_BIT])));
endmodule

// File: tb/dma_regfile_test.sv
module dma_regfile_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, step_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] step_ch = '0;
    logic [3:0] mask_o, auto_o, dir_o, tc_o;
    logic [3:0] tc_seen;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    dma_regfile uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .step_en(step_en), .step_ch(step_ch),
        .mask_o(mask_o), .auto_o(auto_o), .dir_o(dir_o), .tc_o(tc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] ofs, input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; addr = ofs; wdata = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] ofs, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; addr = ofs;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic step(input logic [1:0] c);
        @(negedge clk); step_en = 1'b1; step_ch = c;
        @(negedge clk); step_en = 1'b0; tc_seen = tc_o;
    endtask

    task automatic write16(input logic [3:0] ofs, input logic [15:0] v);
        bus_write(4'd12, 8'hA5);
        bus_write(ofs, v[7:0]);
        bus_write(ofs, v[15:8]);
    endtask

    task automatic read16(input logic [3:0] ofs, output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_write(4'd12, 8'h00);
        bus_read(ofs, lo);
        bus_read(ofs, hi);
        v = {hi, lo};
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1 mask", mask_o, 4'hF);
        check("R1 auto/dir", {auto_o, dir_o}, 8'h00);
        check("R1 tc", tc_o, 4'h0);
        read16(4'd0, v);  check("R1 addr0", v, 16'h0000);
        read16(4'd7, v);  check("R1 cnt3", v, 16'h0000);
    endtask

    task automatic t_offsets;
        logic [15:0] v;
        for (int c = 0; c < 4; c++) begin
            write16(4'(2*c),   16'hA0B0 | 16'(c));
            write16(4'(2*c+1), 16'h0C00 | 16'(c << 4));
        end
        for (int c = 0; c < 4; c++) begin
            read16(4'(2*c), v);   check("R2 addr offset", v, 16'hA0B0 | 16'(c));
            read16(4'(2*c+1), v); check("R2 count offset", v, 16'h0C00 | 16'(c << 4));
        end
    endtask

    task automatic t_pointer;
        logic [7:0] b;
        logic [15:0] v;
        write16(4'd2, 16'h1234);
        bus_write(4'd2, 8'h56);          // third access: low byte
        read16(4'd2, v); check("R4 third write low", v, 16'h1256);
        bus_read(4'd2, b);                // pointer back at low
        check("R4 third read low", b, 8'h56);
        bus_write(4'd12, 8'hFF);          // clear mid-pair
        bus_read(4'd2, b);
        check("R3 clear to low", b, 8'h56);
        bus_read(4'd2, b);
        check("R4 second read high", b, 8'h12);
    endtask

    task automatic t_other_reads;
        logic [7:0] b;
        bus_write(4'd12, 8'h00);
        bus_read(4'd10, b); check("R12 mask port reads 0", b, 8'h00);
        bus_read(4'd2, b);  check("R12 pointer untouched", b, 8'h56);
    endtask

    task automatic t_mask;
        bus_write(4'd10, 8'h01);
        check("R6 unmask ch1", mask_o, 4'b1101);
        bus_write(4'd10, 8'h05);
        check("R6 mask ch1", mask_o, 4'b1111);
    endtask

    task automatic t_mode;
        bus_write(4'd11, 8'h12);
        bus_write(4'd11, 8'h07);
        check("R7 auto", auto_o, 4'b0100);
        check("R7 dir", dir_o, 4'b1000);
    endtask

    task automatic t_step_single;
        logic [15:0] v;
        write16(4'd0, 16'h1000);
        write16(4'd1, 16'h0002);
        bus_write(4'd10, 8'h00);
        step(2'd0);
        read16(4'd0, v); check("R8 addr inc", v, 16'h1001);
        read16(4'd1, v); check("R8 cnt dec", v, 16'h0001);
        step(2'd0);
        check("R9 no early tc", tc_seen, 4'h0);
        step(2'd0);
        check("R9 tc pulse", tc_seen, 4'b0001);
        check("R9 masked at tc", mask_o[0], 1'b1);
        read16(4'd1, v); check("R9 cnt FFFF", v, 16'hFFFF);
        read16(4'd0, v); check("R9 addr", v, 16'h1003);
        step(2'd0);
        check("R11 masked no tc", tc_seen, 4'h0);
        read16(4'd1, v); check("R11 cnt held", v, 16'hFFFF);
        read16(4'd0, v); check("R11 addr held", v, 16'h1003);
    endtask

    task automatic t_step_auto;
        logic [15:0] v;
        write16(4'd4, 16'h2000);
        write16(4'd5, 16'h0001);
        bus_write(4'd10, 8'h02);
        step(2'd2);
        read16(4'd5, v); check("R8 auto cnt dec", v, 16'h0000);
        step(2'd2);
        check("R10 tc pulse", tc_seen, 4'b0100);
        check("R10 stays enabled", mask_o[2], 1'b0);
        read16(4'd5, v); check("R5 R10 cnt reload", v, 16'h0001);
        read16(4'd4, v); check("R5 R10 addr reload", v, 16'h2000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offsets();
        t_pointer();
        t_other_reads();
        t_mask();
        t_mode();
        t_step_single();
        t_step_auto();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule